// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns 8-bit characters into asynchronous serial frames on a single output line. A one-character holding stage sits in front of the frame shifter. Software can therefore queue a second character while the first is still going out, and consecutive characters leave the line with no idle gap between them. Bit timing comes from a baud strobe generated outside the block: each serial bit lasts exactly one strobe period.

Single-cycle command pulses control the transmitter. An enable pulse turns it on. A disable pulse stops it gracefully, after whatever is already queued has been sent. A transmitter-reset pulse stops it at once and throws away anything queued. A 3-bit mode input selects even, odd, forced-0 or forced-1 parity, or no parity bit at all. Two status outputs report whether a new character can be accepted and whether the transmitter has gone completely quiet.

Top module: `sertx_dbuf`

## Requirements
- R1: After the synchronous reset input, the transmitter is disabled: `tx_ready` is 0, `tx_empty` is 1 and `txd` is 1.
- R2: An enable pulse sets `tx_ready` high on the following cycle. When enable and disable are pulsed together, disable wins and `tx_ready` stays 0.
- R3: A frame is a start bit at 0, then 8 data bits with bit 0 first, then an optional parity bit, then a stop bit at 1. Each bit lasts one baud-strobe period. The start bit begins on the first strobe after the character reaches the shifter.
- R4: `par_mode` selects parity: 3'b000 even (the parity bit makes the count of ones even), 3'b001 odd, 3'b010 constant 0, 3'b011 constant 1, and any value with bit 2 set means no parity bit. The mode is sampled when the character enters the shifter.
- R5: A disable pulse while nothing is queued or in flight drops `tx_ready` on the next cycle. Otherwise the character in flight and any held character are both sent in full before the transmitter stops. `tx_ready` is 0 while this drain runs.
- R6: A transmitter-reset pulse takes priority over every other command. On the next cycle `txd` is 1, `tx_empty` is 1 and `tx_ready` is 0, and any held character is never sent.
- R7: `tx_ready` is high while the transmitter is enabled and the holding stage is free. A write into an idle shifter goes straight into the shifter, so `tx_ready` stays high. Only a write that queues behind a frame in flight drops it.
- R8: A write is ignored when `tx_ready` is 0, when the transmitter is disabled or draining, or when it coincides with a disable or reset pulse. An ignored write never appears on `txd`.
- R9: `tx_empty` is 1 exactly when no character is held, waiting for a strobe, or being shifted. Any accepted write makes it 0 on the next cycle.
- R10: A character held when the stop bit of the current frame ends has its start bit begin on that same strobe, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_en | input | 1 | Enable pulse |
| cmd_dis | input | 1 | Graceful disable pulse |
| cmd_rst | input | 1 | Abrupt transmitter-reset pulse |
| par_mode | input | 3 | Parity selection |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send |
| baud_tick | input | 1 | One-cycle baud strobe |
| tx_ready | output | 1 | A write will be accepted |
| tx_empty | output | 1 | Nothing held, pending or shifting |
| txd | output | 1 | Serial line, idle high |

## Verification
The assertions assume that `baud_tick` is a single-cycle strobe. They also assume that command and write inputs are held for exactly one cycle per event, and that `par_mode` is a clean 3-bit value. The bench drives every input at the falling clock edge. It keeps each command and write to a one-cycle pulse, including in the random phase, so nothing is held across an edge by accident. The strobe spacing is switched between every cycle and every fourth cycle. This covers both back-to-back frames at the fastest rate and frames where commands and writes land in the middle of a bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = DATA_W + 3;
    localparam int POS_W     = $clog2(FRAME_MAX);

    typedef enum logic [1:0] {
        TXS_OFF   = 2'd0,
        TXS_ON    = 2'd1,
        TXS_DRAIN = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        PK_EVEN  = 2'b00,
        PK_ODD   = 2'b01,
        PK_SPACE = 2'b10,
        PK_MARK  = 2'b11
    } par_kind_e;

    typedef struct packed {
        logic      off;
        par_kind_e kind;
    } par_mode_t;

    typedef struct packed {
        logic go;
        logic stop;
        logic kill;
    } tx_cmd_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [POS_W-1:0]     last;
    } frame_t;

    typedef struct packed {
        logic             pend;
        logic             act;
        logic [POS_W-1:0] pos;
        frame_t           fr;
    } shift_state_t;

    function automatic logic parity_bit(par_mode_t m, logic [DATA_W-1:0] d);
        case (m.kind)
            PK_EVEN:  return ^d;
            PK_ODD:   return ~^d;
            PK_SPACE: return 1'b0;
            default:  return 1'b1;
        endcase
    endfunction

    function automatic frame_t build_frame(par_mode_t m, logic [DATA_W-1:0] d);
        frame_t f;
        if (m.off) begin
            f.bits = {1'b1, 1'b1, d, 1'b0};
            f.last = POS_W'(DATA_W + 1);
        end else begin
            f.bits = {1'b1, parity_bit(m, d), d, 1'b0};
            f.last = POS_W'(DATA_W + 2);
        end
        return f;
    endfunction

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tx_cmd_t   cmd,
    input  logic      dp_idle,
    output tx_state_e state
);

    tx_state_e nxt;

    always_comb begin
        nxt = state;
        if (cmd.kill) begin
            nxt = TXS_OFF;
        end else if (cmd.stop) begin
            nxt = dp_idle ? TXS_OFF : TXS_DRAIN;
        end else if (cmd.go) begin
            nxt = TXS_ON;
        end else if (state == TXS_DRAIN && dp_idle) begin
            nxt = TXS_OFF;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TXS_OFF;
        end else begin
            state <= nxt;
        end
    end

    // R1: reset leaves the transmitter off
    a_r1_reset_off: assert property (@(posedge clk)
        rst |=> (state == TXS_OFF));

    // R2: disable beats a simultaneous enable
    a_r2_dis_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd.go && cmd.stop) |=> (state != TXS_ON));

    // R5: a drain with work left does not stop early
    a_r5_drain_holds: assert property (@(posedge clk) disable iff (rst)
        (state == TXS_DRAIN && !dp_idle && !cmd.kill && !cmd.go) |=> (state == TXS_DRAIN));

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_accept,
    input  logic              shifter_busy,
    input  logic              take,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    logic park;

    // Only writes that find the shifter occupied are parked here.
    assign park = wr_accept && shifter_busy;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (park) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    // R8: a held character is never overwritten
    a_r8_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (full && !take && !flush) |=> (full && $stable(data)));

    // R6: a flush empties the holding stage
    a_r6_hold_flush: assert property (@(posedge clk) disable iff (rst)
        flush |=> !full);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              baud_tick,
    input  par_mode_t         mode,
    input  logic              direct_load,
    input  logic [DATA_W-1:0] direct_data,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              busy,
    output logic              take,
    output logic              txd
);

    shift_state_t q, d;
    logic         at_last;

    assign at_last = q.act && (q.pos == q.fr.last);
    assign busy    = q.act || q.pend;
    assign take    = hold_full && (!busy || (at_last && baud_tick));
    assign txd     = q.act ? q.fr.bits[q.pos] : 1'b1;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else if (take && busy) begin
            // back-to-back: next start bit begins on this strobe
            d.act  = 1'b1;
            d.pend = 1'b0;
            d.pos  = '0;
            d.fr   = build_frame(mode, hold_data);
        end else if (take) begin
            d.pend = 1'b1;
            d.act  = 1'b0;
            d.pos  = '0;
            d.fr   = build_frame(mode, hold_data);
        end else if (direct_load) begin
            d.pend = 1'b1;
            d.act  = 1'b0;
            d.pos  = '0;
            d.fr   = build_frame(mode, direct_data);
        end else if (q.pend && baud_tick) begin
            d.pend = 1'b0;
            d.act  = 1'b1;
            d.pos  = '0;
        end else if (q.act && baud_tick) begin
            if (at_last) begin
                d.act = 1'b0;
            end else begin
                d.pos = q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R3: a pending frame opens with a low start bit on the strobe
    a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
        (q.pend && baud_tick && !flush) |=> !txd);

    // R3: a bit holds its level between strobes
    a_r3_bit_steady: assert property (@(posedge clk) disable iff (rst)
        (q.act && !baud_tick && !flush) |=> $stable(txd));

    // R3: the final bit of a frame is a high stop bit
    a_r3_stop_high: assert property (@(posedge clk) disable iff (rst)
        at_last |-> txd);

    // R6: flush returns the line to idle high at once
    a_r6_line_idle: assert property (@(posedge clk) disable iff (rst)
        flush |=> (txd && !busy));

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_en,
    input  logic              cmd_dis,
    input  logic              cmd_rst,
    input  logic [2:0]        par_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              baud_tick,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              txd
);

    tx_cmd_t           cmd;
    tx_state_e         state;
    par_mode_t         mode;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              sh_busy;
    logic              sh_take;
    logic              dp_idle;
    logic              wr_accept;

    assign cmd  = '{go: cmd_en, stop: cmd_dis, kill: cmd_rst};
    assign mode = par_mode_t'(par_mode);

    assign dp_idle   = !hold_full && !sh_busy;
    assign wr_accept = wr_en && (state == TXS_ON) && !hold_full && !cmd_dis && !cmd_rst;

    sertx_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .dp_idle (dp_idle),
        .state   (state)
    );

    sertx_hold u_hold (
        .clk          (clk),
        .rst          (rst),
        .flush        (cmd_rst),
        .wr_accept    (wr_accept),
        .shifter_busy (sh_busy),
        .take         (sh_take),
        .wr_data      (wr_data),
        .full         (hold_full),
        .data         (hold_data)
    );

    sertx_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .flush       (cmd_rst),
        .baud_tick   (baud_tick),
        .mode        (mode),
        .direct_load (wr_accept && !sh_busy),
        .direct_data (wr_data),
        .hold_full   (hold_full),
        .hold_data   (hold_data),
        .busy        (sh_busy),
        .take        (sh_take),
        .txd         (txd)
    );

    assign tx_ready = (state == TXS_ON) && !hold_full;
    assign tx_empty = dp_idle;

    // R9: an accepted write always leaves work behind
    a_r9_accept_busy: assert property (@(posedge clk) disable iff (rst)
        wr_accept |=> !tx_empty);

    // R6: reset command quiets every output
    a_r6_kill_quiet: assert property (@(posedge clk) disable iff (rst)
        cmd_rst |=> (txd && tx_empty && !tx_ready));

    // R7: a write into an idle shifter keeps ready high
    a_r7_ready_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_accept && !sh_busy && !cmd_en) |=> tx_ready);

endmodule

// File: tb/sertx_dbuf_tb.sv
module sertx_dbuf_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_en = 1'b0, cmd_dis = 1'b0, cmd_rst = 1'b0;
    logic [2:0] par_mode = 3'b100;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       baud_tick = 1'b0;
    logic       tx_ready, tx_empty, txd;

    int n_chk = 0, n_fail = 0, cycles = 0, tick_div = 4, tick_cnt = 0;
    bit done = 0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    sertx_dbuf u_dut (
        .clk(clk), .rst(rst), .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_rst(cmd_rst),
        .par_mode(par_mode), .wr_en(wr_en), .wr_data(wr_data), .baud_tick(baud_tick),
        .tx_ready(tx_ready), .tx_empty(tx_empty), .txd(txd)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st = 0;           // 0 off, 1 on, 2 draining
    int m_hold[$];
    bit m_pend = 0, m_act = 0;
    bit m_bits[$];

    function automatic void frame_of(input int dv, input int md, ref bit q[$]);
        int ones = 0;
        q.delete();
        q.push_back(1'b0);
        for (int i = 0; i < 8; i++) begin
            q.push_back(bit'((dv >> i) & 1));
            ones += (dv >> i) & 1;
        end
        if (md < 4) begin
            case (md)
                0: q.push_back(bit'(ones % 2));
                1: q.push_back(bit'(1 - ones % 2));
                2: q.push_back(1'b0);
                default: q.push_back(1'b1);
            endcase
        end
        q.push_back(1'b1);
    endfunction

    always @(posedge clk) begin
        bit hold_old, busy_old, acc;
        hold_old = m_hold.size() > 0;
        busy_old = m_pend || m_act;
        acc = wr_en && m_st == 1 && !hold_old && !cmd_dis && !cmd_rst;
        if (rst || cmd_rst) begin
            m_st = 0; m_hold.delete(); m_pend = 0; m_act = 0; m_bits.delete();
        end else begin
            if (cmd_dis) m_st = (!hold_old && !busy_old) ? 0 : 2;
            else if (cmd_en) m_st = 1;
            else if (m_st == 2 && !hold_old && !busy_old) m_st = 0;
            if (m_act && baud_tick) begin
                void'(m_bits.pop_front());
                if (m_bits.size() == 0) begin
                    if (hold_old) frame_of(m_hold.pop_front(), int'(par_mode), m_bits);
                    else m_act = 0;
                end
            end else if (m_pend && baud_tick) begin
                m_pend = 0; m_act = 1;
            end
            if (!busy_old && hold_old) begin
                frame_of(m_hold.pop_front(), int'(par_mode), m_bits);
                m_pend = 1;
            end
            if (acc) begin
                if (busy_old) m_hold.push_back(int'(wr_data));
                else begin
                    frame_of(int'(wr_data), int'(par_mode), m_bits);
                    m_pend = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(phase, "txd", int'(txd), m_act ? int'(m_bits[0]) : 1);
            chk("R7", "tx_ready", int'(tx_ready), (m_st == 1 && m_hold.size() == 0) ? 1 : 0);
            chk("R9", "tx_empty", int'(tx_empty), (m_hold.size() == 0 && !m_pend && !m_act) ? 1 : 0);
        end
    end

    // ---------------- baud strobe ----------------
    initial begin
        forever begin
            @(negedge clk);
            tick_cnt++;
            if (tick_cnt >= tick_div) begin
                tick_cnt = 0;
                baud_tick = 1'b1;
            end else begin
                baud_tick = 1'b0;
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 120000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog for all R tags: actual %0d expected below 120000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input bit e, input bit ds, input bit r);
        cmd_en = e; cmd_dis = ds; cmd_rst = r;
        cyc(1);
        cmd_en = 1'b0; cmd_dis = 1'b0; cmd_rst = 1'b0;
    endtask

    task automatic expect_frame(input int dv, input int md, input bit chained, input string tag);
        bit eb[$];
        int w = 0;
        frame_of(dv, md, eb);
        if (!chained) begin
            while (txd !== 1'b0 && w < 80) begin cyc(1); w++; end
        end
        foreach (eb[i]) begin
            chk(tag, $sformatf("frame %02h bit %0d", dv, i), int'(txd), int'(eb[i]));
            cyc(tick_div);
        end
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1: reset state
        chk("R1", "ready after reset", int'(tx_ready), 0);
        chk("R1", "empty after reset", int'(tx_empty), 1);
        chk("R1", "line after reset", int'(txd), 1);

        // R8: write while disabled is dropped
        phase = "R8";
        wr(8'h5A);
        cyc(30);
        chk("R8", "line stays idle while disabled", int'(txd), 1);
        chk("R8", "empty stays high while disabled", int'(tx_empty), 1);

        // R2: disable wins over a simultaneous enable, then plain enable
        phase = "R2";
        pulse(1, 1, 0);
        chk("R2", "ready after en+dis", int'(tx_ready), 0);
        pulse(1, 0, 0);
        chk("R2", "ready after enable", int'(tx_ready), 1);

        // R3 / R4: one frame per parity setting
        phase = "R4";
        for (int md = 0; md < 5; md++) begin
            logic [7:0] v;
            v = 8'hA5 ^ 8'(md * 8'h37);
            par_mode = 3'(md);
            wr(v);
            chk("R7", "ready kept after direct load", int'(tx_ready), 1);
            expect_frame(int'(v), md, 0, md == 4 ? "R3" : "R4");
            cyc(6);
        end
        par_mode = 3'b111;
        wr(8'h81);
        expect_frame(8'h81, 7, 0, "R4");
        cyc(6);

        // R10 / R7 / R8: queued character follows with no gap, third write dropped
        phase = "R10";
        par_mode = 3'b001;
        wr(8'h55);
        wr(8'hC3);
        chk("R7", "ready low with queued char", int'(tx_ready), 0);
        wr(8'hEE);
        expect_frame(8'h55, 1, 0, "R3");
        expect_frame(8'hC3, 1, 1, "R10");
        cyc(12);
        chk("R8", "dropped write never sent", int'(txd), 1);
        chk("R9", "empty after both frames", int'(tx_empty), 1);

        // R5: graceful disable drains both
        phase = "R5";
        par_mode = 3'b100;
        wr(8'h12);
        wr(8'h34);
        pulse(0, 1, 0);
        chk("R5", "ready low while draining", int'(tx_ready), 0);
        wr(8'h99);
        expect_frame(8'h12, 4, 0, "R5");
        expect_frame(8'h34, 4, 1, "R5");
        cyc(12);
        chk("R5", "stopped after drain", int'(tx_ready), 0);
        chk("R5", "empty after drain", int'(tx_empty), 1);
        wr(8'h77);
        cyc(20);
        chk("R8", "no frame after stop", int'(txd), 1);
        pulse(1, 0, 0);
        pulse(0, 1, 0);
        chk("R5", "idle disable immediate", int'(tx_ready), 0);

        // R6: abrupt reset mid-frame
        phase = "R6";
        pulse(1, 0, 0);
        wr(8'h00);
        wr(8'hF0);
        cyc(9);
        pulse(1, 0, 1);
        chk("R6", "line high after reset cmd", int'(txd), 1);
        chk("R6", "empty after reset cmd", int'(tx_empty), 1);
        chk("R6", "ready low after reset cmd", int'(tx_ready), 0);
        cyc(60);
        chk("R6", "held char discarded", int'(txd), 1);

        // random mix against the model
        phase = "R3";
        pulse(1, 0, 0);
        for (int k = 0; k < 6000; k++) begin
            if (k % 1500 == 0) tick_div = (tick_div == 1) ? 4 : 1;
            if ($urandom_range(0, 49) == 0) par_mode = 3'($urandom_range(0, 7));
            wr_en   = ($urandom_range(0, 2) == 0);
            wr_data = 8'($urandom);
            cmd_en  = ($urandom_range(0, 39) == 0);
            cmd_dis = ($urandom_range(0, 149) == 0);
            cmd_rst = ($urandom_range(0, 399) == 0);
            cyc(1);
        end
        wr_en = 0; cmd_en = 0; cmd_dis = 0; cmd_rst = 0;
        cyc(100);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule